// File: doc/BRIEF.md
# Programmable One-Shot / Periodic Interrupt Timer

This block counts timebase ticks and raises a one-cycle timeout pulse each time a programmed delay has passed. A 4-bit setting selects the delay and chooses between one-shot and periodic operation. A separate run/halt control gates the counting. The timeout pulse is meant to set an interrupt flag that lives outside the block. The block also reports whether the timer is currently halted.

Software programs a setting first and then issues an explicit start. A setting of all zeros means "no interrupt" and keeps the timer halted. A one-shot timer halts itself after its timeout. A periodic timer reloads and keeps running. Any halt followed by a start gives a full delay before the next timeout.

Top module: `pit_timer`

## Requirements
- R1: After reset the timer is halted (`halted_o` = 1), no pulse is emitted (`timeout_o` = 0), and the stored setting is 0.
- R2: In the setting, bit 3 selects periodic (1) or one-shot (0) operation. Bits 2:0 form an index k, and the delay is `PERIOD_BASE << k` ticks. `timeout_o` is high in the cycle after the clock edge that samples the tick completing the delay.
- R3: A setting write halts the timer and clears its count, whatever the value written. Counting resumes only after a start write. If a setting write and a run/halt write occur in the same cycle, the setting write wins.
- R4: While the stored setting is 0, the timer stays halted, and a start write has no effect on `halted_o` or `timeout_o`.
- R5: A run/halt write with data 1 halts the timer and clears its count. A write with data 0 starts it, and the first timeout then follows a full delay.
- R6: In one-shot mode the timer halts itself on the same edge that produces its timeout pulse.
- R7: In periodic mode the timer reloads after each timeout and keeps producing a pulse every delay period without further writes.
- R8: The count advances only on cycles where `tick_i` is high. A pulse is always preceded, one cycle earlier, by a sampled tick.
- R9: Each timeout produces exactly one cycle of `timeout_o`.
- R10: If a halt write or a setting write arrives in the same cycle as the tick that would complete the delay, the pulse is suppressed.
- R11: A start write that coincides with a tick clears the count, and that tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Timebase tick, one cycle per count step |
| set_we_i | input | 1 | Setting write strobe |
| set_data_i | input | 4 | Setting value: bit 3 periodic, bits 2:0 delay index |
| run_we_i | input | 1 | Run/halt write strobe |
| run_data_i | input | 1 | 1 halts and clears, 0 starts |
| timeout_o | output | 1 | One-cycle timeout pulse |
| halted_o | output | 1 | Current run/halt state, 1 = halted |

## Verification
A completing tick can coincide with a halt write, with a setting write, or with a start write. Each of these collisions is produced on purpose by advancing the counter to one tick short of the delay and then issuing the write together with the final tick. The outcome is judged in the following cycle: no pulse for a halt or setting write, and a restarted count for a start. A behavioural model in the bench compares `timeout_o` and `halted_o` on every clock through all of these phases.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int unsigned SEL_W   = 3;
  localparam int unsigned NUM_PER = 1 << SEL_W;

  typedef struct packed {
    logic             rpt;
    logic [SEL_W-1:0] sel;
  } pit_cfg_t;
endpackage

// File: rtl/pit_cfg_reg.sv
module pit_cfg_reg
  import pit_pkg::*;
#(
  parameter int unsigned PERIOD_BASE = 1,
  parameter int unsigned CW          = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  pit_cfg_t      wdata_i,
  output pit_cfg_t      cfg_o,
  output logic [CW-1:0] period_o,
  output logic          none_o
);
  pit_cfg_t      cfg_q, cfg_d;
  logic [CW-1:0] tab [NUM_PER];

  genvar gi;
  generate
    for (gi = 0; gi < NUM_PER; gi++) begin : g_tab
      localparam int unsigned PV = PERIOD_BASE << gi;
      assign tab[gi] = CW'(PV);
    end
  endgenerate

  always_comb begin
    cfg_d = cfg_q;
    if (we_i) cfg_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign cfg_o    = cfg_q;
  assign period_o = tab[cfg_q.sel];
  assign none_o   = (cfg_q == '0);

  // R2
  period_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_o != '0);
endmodule

// File: rtl/pit_run_ctl.sv
module pit_run_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_we_i,
  input  logic run_we_i,
  input  logic run_halt_i,
  input  logic none_i,
  input  logic rpt_i,
  input  logic fire_i,
  output logic halted_o
);
  logic halt_q, halt_d;

  always_comb begin
    halt_d = halt_q;
    if (cfg_we_i)               halt_d = 1'b1;
    else if (run_we_i)          halt_d = run_halt_i | none_i;
    else if (fire_i && !rpt_i)  halt_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) halt_q <= 1'b1;
    else        halt_q <= halt_d;
  end

  assign halted_o = halt_q;

  // R4
  zero_cfg_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    none_i |-> halted_o);
  // R3
  cfg_write_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we_i |=> halted_o);
endmodule

// File: rtl/pit_tick_cnt.sv
module pit_tick_cnt #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic [CW-1:0] period_i,
  output logic          fire_o,
  output logic          pulse_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          pulse_q, pulse_d;
  logic          last;
  logic          step_en;

  assign last    = (cnt_q == period_i - CW'(1));
  assign step_en = run_i && tick_i && !clear_i;
  assign fire_o  = step_en && last;

  always_comb begin
    cnt_d   = cnt_q;
    pulse_d = fire_o;
    if (clear_i)      cnt_d = '0;
    else if (step_en) cnt_d = last ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse_o = pulse_q;

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q < period_i));
  // R8
  tick_before_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> $past(tick_i));
endmodule

// File: rtl/pit_timer.sv
module pit_timer
  import pit_pkg::*;
#(
  parameter int unsigned PERIOD_BASE = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       set_we_i,
  input  logic [3:0] set_data_i,
  input  logic       run_we_i,
  input  logic       run_data_i,
  output logic       timeout_o,
  output logic       halted_o
);
  localparam int unsigned MAXP = PERIOD_BASE << (NUM_PER - 1);
  localparam int unsigned CW   = $clog2(MAXP) + 1;

  logic          rs_q1, rs_q2;
  logic          rst_s_n;
  pit_cfg_t      cfg;
  logic [CW-1:0] period;
  logic          none;
  logic          fire;
  logic          halted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_q2 <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_q2 <= rs_q1;
    end
  end
  assign rst_s_n = rs_q2;

  pit_cfg_reg #(.PERIOD_BASE(PERIOD_BASE), .CW(CW)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .we_i     (set_we_i),
    .wdata_i  (pit_cfg_t'(set_data_i)),
    .cfg_o    (cfg),
    .period_o (period),
    .none_o   (none)
  );

  pit_run_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .cfg_we_i   (set_we_i),
    .run_we_i   (run_we_i),
    .run_halt_i (run_data_i),
    .none_i     (none),
    .rpt_i      (cfg.rpt),
    .fire_i     (fire),
    .halted_o   (halted)
  );

  pit_tick_cnt #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .clear_i  (set_we_i | run_we_i),
    .run_i    (!halted),
    .tick_i   (tick_i),
    .period_i (period),
    .fire_o   (fire),
    .pulse_o  (timeout_o)
  );

  assign halted_o = halted;

  // R6
  oneshot_self_halt_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (timeout_o && !cfg.rpt) |-> halted_o);
  // R10
  halt_suppress_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (run_we_i && run_data_i) |=> !timeout_o);
  // R10
  cfg_suppress_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    set_we_i |=> !timeout_o);
endmodule

// File: tb/pit_timer_bench.sv
module pit_timer_bench;
  localparam int BASE = 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       set_we_i = 1'b0;
  logic [3:0] set_data_i = 4'd0;
  logic       run_we_i = 1'b0;
  logic       run_data_i = 1'b0;
  logic       timeout_o;
  logic       halted_o;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  // behavioural reference state
  int m_cfg = 0;
  int m_halt = 1;
  int m_cnt = 0;
  int m_pulse = 0;

  always #5 clk = ~clk;

  pit_timer #(.PERIOD_BASE(BASE)) u_pit_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .set_we_i(set_we_i), .set_data_i(set_data_i),
    .run_we_i(run_we_i), .run_data_i(run_data_i),
    .timeout_o(timeout_o), .halted_o(halted_o)
  );

  always @(posedge clk) begin
    int per;
    int fire;
    if (!rst_n) begin
      m_cfg = 0; m_halt = 1; m_cnt = 0; m_pulse = 0;
    end else begin
      per  = BASE << (m_cfg % 8);
      fire = (m_halt == 0 && tick_i && m_cnt == per - 1 && !set_we_i && !run_we_i) ? 1 : 0;
      m_pulse = fire;
      if (set_we_i) begin
        m_cfg = int'(set_data_i); m_halt = 1; m_cnt = 0;
      end else if (run_we_i) begin
        m_cnt = 0;
        m_halt = (run_data_i || m_cfg == 0) ? 1 : 0;
      end else if (m_halt == 0 && tick_i) begin
        if (fire != 0) begin
          m_cnt = 0;
          if (m_cfg < 8) m_halt = 1;
        end else m_cnt++;
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check(cur_req, "model halted", int'(halted_o), m_halt);
      check(cur_req, "model timeout", int'(timeout_o), m_pulse);
    end
  end

  task automatic idle_all();
    tick_i = 0; set_we_i = 0; run_we_i = 0; run_data_i = 0;
  endtask

  task automatic run(input int n, input int gap, output int pulses);
    pulses = 0;
    for (int i = 0; i < n; i++) begin
      tick_i = (gap > 0 && (i % gap) == gap - 1);
      @(negedge clk);
      if (timeout_o) pulses++;
    end
    tick_i = 0;
  endtask

  task automatic wr_set(input logic [3:0] v, input logic tk);
    set_we_i = 1; set_data_i = v; tick_i = tk;
    @(negedge clk);
    idle_all();
  endtask

  task automatic wr_run(input logic d, input logic tk);
    run_we_i = 1; run_data_i = d; tick_i = tk;
    @(negedge clk);
    idle_all();
  endtask

  initial begin
    #(20000 * 10);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int p;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    cur_req = "R1";
    check("R1", "halted after reset", int'(halted_o), 1);
    check("R1", "no pulse after reset", int'(timeout_o), 0);

    cur_req = "R4";
    wr_run(1'b0, 1'b0);
    check("R4", "start ignored with zero setting", int'(halted_o), 1);
    run(6, 1, p);
    check("R4", "no pulses with zero setting", p, 0);

    cur_req = "R3";
    wr_set(4'b1010, 1'b0);
    check("R3", "setting write halts", int'(halted_o), 1);
    run(6, 1, p);
    check("R3", "no count before start", p, 0);

    cur_req = "R7";
    wr_run(1'b0, 1'b0);
    check("R5", "start runs", int'(halted_o), 0);
    run(20, 1, p);
    check("R7", "periodic pulses over 20 ticks, delay 4", p, 5);

    cur_req = "R8";
    run(24, 3, p);
    check("R8", "pulses over 8 sparse ticks", p, 2);

    cur_req = "R5";
    wr_run(1'b1, 1'b0);
    run(10, 1, p);
    check("R5", "halted: no pulses", p, 0);
    check("R5", "halted state", int'(halted_o), 1);
    wr_run(1'b0, 1'b0);
    run(3, 1, p);
    check("R5", "restart: none before full delay", p, 0);
    run(1, 1, p);
    check("R5", "restart: pulse at full delay", p, 1);

    cur_req = "R6";
    wr_set(4'b0011, 1'b0);
    wr_run(1'b0, 1'b0);
    run(30, 1, p);
    check("R6", "one-shot gives single pulse", p, 1);
    check("R6", "one-shot halts itself", int'(halted_o), 1);

    cur_req = "R10";
    wr_set(4'b1001, 1'b0);
    wr_run(1'b0, 1'b0);
    run(1, 1, p);
    wr_run(1'b1, 1'b1);
    check("R10", "halt with completing tick suppresses", int'(timeout_o), 0);
    wr_run(1'b0, 1'b0);
    run(1, 1, p);
    wr_set(4'b1001, 1'b1);
    check("R10", "setting write with completing tick suppresses", int'(timeout_o), 0);

    cur_req = "R11";
    wr_run(1'b0, 1'b1);
    run(1, 1, p);
    check("R11", "coinciding tick not counted", p, 0);
    run(1, 1, p);
    check("R11", "pulse after two further ticks", p, 1);

    cur_req = "R9";
    wr_set(4'b1000, 1'b0);
    wr_run(1'b0, 1'b0);
    run(10, 2, p);
    check("R9", "one pulse cycle per timeout, delay 1", p, 5);

    cur_req = "R2";
    wr_set(4'b0101, 1'b0);
    wr_run(1'b0, 1'b0);
    run(31, 1, p);
    check("R2", "no pulse before 32 ticks", p, 0);
    run(1, 1, p);
    check("R2", "pulse at tick 32", p, 1);

    cur_req = "R4";
    wr_set(4'b1001, 1'b0);
    wr_run(1'b0, 1'b0);
    wr_set(4'b0000, 1'b0);
    wr_run(1'b0, 1'b0);
    check("R4", "zero setting keeps halted after start", int'(halted_o), 1);
    run(8, 1, p);
    check("R4", "zero setting gives no pulse", p, 0);

    cur_req = "R3";
    wr_set(4'b1001, 1'b0);
    set_we_i = 1; set_data_i = 4'b1001; run_we_i = 1; run_data_i = 0;
    @(negedge clk);
    idle_all();
    check("R3", "setting write beats start", int'(halted_o), 1);

    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule